// File: doc/BRIEF.md
# Per-Cycle Device Clock Stepper

This block lets a host-side software model advance a purely synchronous device under test by an exact number of clock cycles and then hold it frozen while the host exchanges data with it. The host reaches the block through a small synchronous register port. Writes are taken on the clock edge. Read data is a combinational selection of registered state and of the device outputs.

The host works in a fixed order on every step. It reads the device outputs, writes new device input words, programs a cycle count and issues a start command. It then polls the status until the run is complete. During a run the block drives a single clock-enable, `dev_ce_o`, that every register of the device must honour. The enable is high for exactly the programmed number of whole cycles and low at all other times.

The cycle count is kept after a run, so the same step can be repeated by issuing another start command. Device input words cannot be changed while a run is in progress. Start commands that arrive during a run have no effect.

Top module: `cycle_stepper`

## Requirements
- R1: After reset, `dev_ce_o` is low, the status word (address 1) reads 0, the count register (address 2) and the remaining count (address 3) read 0, and every device input word is 0.
- R2: The count register is 16 bits wide at address 2. It can be written and read back, and it keeps its value after a run completes.
- R3: A write to address 0 with bit 0 set, while idle and with count N > 0, raises `dev_ce_o` in the cycle after the write edge. The enable stays high for exactly N consecutive cycles and then goes low.
- R4: Status bit 0 reads 1 (busy) while cycles remain. Status bit 1 reads 1 (done) once a run has completed. An accepted start clears done, and busy and done are never 1 together.
- R5: A start with count 0 sets done on the write edge, leaves busy at 0 and produces no enable cycle.
- R6: A start command written while busy is ignored. The run in progress keeps its length, and done is not set early.
- R7: Device input word i is read and written at address 4+i and drives slice i of `dev_in_o`. Writes to these addresses are discarded while busy and accepted while idle.
- R8: Device output word j, taken from slice j of `dev_out_i`, reads at address 4+N_IN+j.
- R9: The remaining count at address 3 is loaded with N when a start is accepted. It falls by one on every enabled cycle and reaches 0 when the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | ADDR_W | Host register address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data for the current address |
| dev_ce_o | output | 1 | Clock-enable to the device |
| dev_in_o | output | N_IN*DATA_W | Device input words |
| dev_out_i | input | N_OUT*DATA_W | Device output words |

## Verification
The bench attaches a small device model to the block: a cycle counter and an accumulator of input word 0, both advanced only under the enable. It sweeps every count from 0 to 40, plus a long run. Each step uses a different input word, so a wrong enable length, an extra enable cycle or a stale input value each produces a different counter or accumulator total. Separate runs issue a start mid-run and write an input word mid-run. These show whether a busy-time command leaks into the run length or into the data the device sees. A zero count separates immediate completion from a one-cycle pulse.

// File: rtl/cycle_stepper_pkg.sv
package cycle_stepper_pkg;
  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_STAT   = 1;
  localparam int unsigned ADDR_COUNT  = 2;
  localparam int unsigned ADDR_REMAIN = 3;
  localparam int unsigned ADDR_IO     = 4;

  typedef struct packed {
    logic done;
    logic busy;
  } stat_t;
endpackage

// File: rtl/step_sequencer.sv
module step_sequencer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] remain_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else if (busy_q) begin
      rem_q <= rem_q - CNT_W'(1);
      if (rem_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else if (start_i) begin
      rem_q <= count_i;
      if (count_i == '0) begin
        done_q <= 1'b1;
      end else begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign remain_o = rem_q;
endmodule

// File: rtl/io_word_bank.sv
module io_word_bank #(
  parameter int unsigned N_WORDS = 2,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned BASE    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic                      lock_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [N_WORDS*DATA_W-1:0] words_o
);
  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              hit;
    assign hit = we_i && !lock_i && (addr_i == ADDR_W'(BASE + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  word_q <= '0;
      else if (hit) word_q <= wdata_i;
    end
    assign words_o[i*DATA_W +: DATA_W] = word_q;
  end
endmodule

// File: rtl/host_read_mux.sv
module host_read_mux
  import cycle_stepper_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned N_IN   = 2,
  parameter int unsigned N_OUT  = 2
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  stat_t                   stat_i,
  input  logic [CNT_W-1:0]        count_i,
  input  logic [CNT_W-1:0]        remain_i,
  input  logic [N_IN*DATA_W-1:0]  in_words_i,
  input  logic [N_OUT*DATA_W-1:0] out_words_i,
  output logic [DATA_W-1:0]       rdata_o
);
  localparam int unsigned OUT_BASE = ADDR_IO + N_IN;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_STAT))   rdata_o = DATA_W'(stat_i);
    if (addr_i == ADDR_W'(ADDR_COUNT))  rdata_o = DATA_W'(count_i);
    if (addr_i == ADDR_W'(ADDR_REMAIN)) rdata_o = DATA_W'(remain_i);
    for (int i = 0; i < N_IN; i++)
      if (addr_i == ADDR_W'(ADDR_IO + i)) rdata_o = in_words_i[i*DATA_W +: DATA_W];
    for (int j = 0; j < N_OUT; j++)
      if (addr_i == ADDR_W'(OUT_BASE + j)) rdata_o = out_words_i[j*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/cycle_stepper.sv
module cycle_stepper
  import cycle_stepper_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned N_IN   = 2,
  parameter int unsigned N_OUT  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      host_we_i,
  input  logic [ADDR_W-1:0]         host_addr_i,
  input  logic [DATA_W-1:0]         host_wdata_i,
  output logic [DATA_W-1:0]         host_rdata_o,
  output logic                      dev_ce_o,
  output logic [N_IN*DATA_W-1:0]    dev_in_o,
  input  logic [N_OUT*DATA_W-1:0]   dev_out_i
);
  localparam int unsigned MAP_END = ADDR_IO + N_IN + N_OUT;

  initial begin
    if (DATA_W < CNT_W) $error("cycle_stepper: DATA_W narrower than CNT_W");
    if (MAP_END > (1 << ADDR_W)) $error("cycle_stepper: address space too small");
  end

  logic             start_w, busy_w, done_w;
  logic [CNT_W-1:0] cnt_q, remain_w;
  stat_t            stat_w;

  assign start_w = host_we_i && (host_addr_i == ADDR_W'(ADDR_CTRL)) && host_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (host_we_i && host_addr_i == ADDR_W'(ADDR_COUNT)) cnt_q <= host_wdata_i[CNT_W-1:0];
  end

  step_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_w),
    .count_i  (cnt_q),
    .busy_o   (busy_w),
    .done_o   (done_w),
    .remain_o (remain_w)
  );

  io_word_bank #(
    .N_WORDS (N_IN),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .BASE    (ADDR_IO)
  ) u_in_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (host_we_i),
    .lock_i  (busy_w),
    .addr_i  (host_addr_i),
    .wdata_i (host_wdata_i),
    .words_o (dev_in_o)
  );

  assign stat_w.busy = busy_w;
  assign stat_w.done = done_w;

  host_read_mux #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .N_IN   (N_IN),
    .N_OUT  (N_OUT)
  ) u_rmux (
    .addr_i      (host_addr_i),
    .stat_i      (stat_w),
    .count_i     (cnt_q),
    .remain_i    (remain_w),
    .in_words_i  (dev_in_o),
    .out_words_i (dev_out_i),
    .rdata_o     (host_rdata_o)
  );

  // enable straight from the busy flop: whole cycles only
  assign dev_ce_o = busy_w;
endmodule

// File: rtl/cycle_stepper_chk.sv
module cycle_stepper_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned IN_W   = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy,
  input logic             done,
  input logic             start,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] remain,
  input logic             dev_ce_o,
  input logic [IN_W-1:0]  dev_in_o
);
  // R4
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && done));

  // R4
  end_sets_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done);

  // R9
  remain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> remain == $past(remain) - CNT_W'(1));

  // R3
  ce_has_cycles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_ce_o |-> remain != '0);

  // R5
  zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !busy && count == '0) |=> done && !dev_ce_o);

  // R6
  start_busy_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && busy && remain > CNT_W'(1)) |=> busy && !done);

  // R7
  in_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(dev_in_o));
endmodule

bind cycle_stepper cycle_stepper_chk #(
  .CNT_W (CNT_W),
  .IN_W  (N_IN*DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy     (busy_w),
  .done     (done_w),
  .start    (start_w),
  .count    (cnt_q),
  .remain   (remain_w),
  .dev_ce_o (dev_ce_o),
  .dev_in_o (dev_in_o)
);

// File: tb/cycle_stepper_bench.sv
`timescale 1ns/1ps
module cycle_stepper_bench;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 4;
  localparam int unsigned NI = 2;
  localparam int unsigned NO = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          ce;
  logic [NI*DW-1:0] dev_in;
  logic [NO*DW-1:0] dev_out;

  int errors = 0;
  int checks = 0;
  int ce_cnt = 0;

  // device model: cycle counter and accumulator of input word 0
  logic [DW-1:0] d_cnt = '0, d_acc = '0;
  always @(posedge clk) begin
    if (ce) begin
      d_cnt <= d_cnt + 1'b1;
      d_acc <= d_acc + dev_in[DW-1:0];
    end
  end
  assign dev_out = {d_acc, d_cnt};
  always @(posedge clk) if (ce) ce_cnt = ce_cnt + 1;

  always #4 clk = ~clk;

  cycle_stepper #(.CNT_W(16), .DATA_W(DW), .ADDR_W(AW), .N_IN(NI), .N_OUT(NO)) u_cycle_stepper (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .dev_ce_o(ce),
    .dev_in_o(dev_in), .dev_out_i(dev_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wdata = DW'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic peek(input int a, output logic [DW-1:0] d);
    addr = AW'(a);
    #1 d = rdata;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic wait_done(input string req);
    logic [DW-1:0] s;
    for (int k = 0; k < 70000; k++) begin
      peek(1, s);
      if (s[1]) return;
      @(negedge clk);
    end
    check(req, 32'hdead, 32'h0);
  endtask

  logic [DW-1:0] r;
  logic [DW-1:0] exp_cnt = '0, exp_acc = '0;

  task automatic run_step(input int n, input int in0);
    wr(4, in0);
    wr(2, n);
    ce_cnt = 0;
    wr(0, 1);
    peek(3, r);
    check("R9 remaining loaded", r, n);
    wait_done("R3 run completes");
    exp_cnt = exp_cnt + DW'(n);
    exp_acc = exp_acc + DW'(n * in0);
    check("R3 enable cycle count", ce_cnt, n);
    peek(1, r); check("R4 status done", r, 2);
    peek(3, r); check("R9 remaining zero", r, 0);
    peek(2, r); check("R2 count kept", r, n);
    peek(6, r); check("R8 out word0 counter", r, exp_cnt);
    peek(7, r); check("R8 out word1 accumulator", r, exp_acc);
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 ce low", ce, 0);
    rd(1, r); check("R1 status", r, 0);
    rd(2, r); check("R1 count", r, 0);
    rd(3, r); check("R1 remaining", r, 0);
    rd(4, r); check("R1 input word0", r, 0);
    check("R1 dev_in", dev_in, 0);

    // R2 count readback
    wr(2, 16'hA5C3); rd(2, r); check("R2 count rw", r, 16'hA5C3);
    // R7 input write while idle
    wr(5, 16'h1234); rd(5, r); check("R7 input word1 rw", r, 16'h1234);
    check("R7 dev_in slice1", dev_in[DW +: DW], 16'h1234);

    // R5 zero count
    wr(2, 0); ce_cnt = 0; wr(0, 1);
    peek(1, r); check("R5 done at once", r, 2);
    repeat (3) @(negedge clk);
    check("R5 no enable", ce_cnt, 0);

    // R3 enable rises in the cycle after the write edge
    wr(2, 3); wr(0, 1);
    check("R3 enable high after start", ce, 1);
    peek(1, r); check("R4 busy during run", r, 1);
    wait_done("R3 short run");
    exp_cnt = exp_cnt + 3;
    check("R3 three cycles", ce_cnt, 3);

    // sweep counts with varying input words
    for (int n = 0; n <= 40; n++) run_step(n, n * 3 + 1);
    run_step(1000, 7);

    // R6 start while busy ignored
    wr(4, 2); wr(2, 10); ce_cnt = 0; wr(0, 1);
    wr(0, 1);
    peek(1, r); check("R6 still busy", r, 1);
    wait_done("R6 run completes");
    check("R6 run length unchanged", ce_cnt, 10);
    exp_cnt = exp_cnt + 10; exp_acc = exp_acc + 20;

    // R7 input write while busy discarded
    wr(2, 8); ce_cnt = 0; wr(0, 1);
    wr(4, 16'hBEEF);
    wait_done("R7 run completes");
    exp_cnt = exp_cnt + 8; exp_acc = exp_acc + 16;
    peek(4, r); check("R7 input unchanged", r, 2);
    peek(7, r); check("R7 accumulator used old input", r, exp_acc);
    peek(6, r); check("R8 counter after runs", r, exp_cnt);

    // R2 repeat with kept count
    ce_cnt = 0; wr(0, 1);
    wait_done("R2 repeat run");
    check("R2 repeat uses kept count", ce_cnt, 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule